// File: doc/BRIEF.md
# User-Mode Interrupt Starvation Watchdog

This block guards a small multitasking processor against a user process that keeps pending interrupts from ever being taken. Such a process might mask interrupts for too long or halt the core with a stop instruction. The block watches two signals: the active-low interrupt request and the flag that says the core runs in user mode. It measures how long a request has stayed pending without a break while user code runs.

When that interval reaches a programmable limit, the block pulls the processor's reset low for a fixed number of clocks. It resets only the core. Every peripheral keeps its state, including the register that holds the current process number and the control that hides the boot ROM. The kernel's reset handler can then kill the offending process and take the pending interrupt.

A sticky flag records that the watchdog fired, so the kernel can tell a watchdog kill apart from a power-on reset. The kernel clears the flag with a one-cycle strobe.

Top module: `irq_starve_wdog`

## Requirements
- R1: On every clock edge where `irq_ni` is 0 and `user_mode_i` is 1, the internal interval count increases by one.
- R2: On any edge where `user_mode_i` is 0, the interval count returns to zero, so supervisor time never adds up toward a trip.
- R3: On any edge where `irq_ni` is 1, the interval count returns to zero, so only one unbroken pending interval is measured.
- R4: With a nonzero `limit_i` of L, `cpu_rst_no` goes low right after the clock edge that completes the L-th consecutive qualifying cycle.
- R5: `cpu_rst_no` stays low for exactly PULSE_LEN clocks (4 by default), then returns high. Inputs are ignored while it is low, and counting restarts from zero afterwards.
- R6: A `limit_i` of 0 disables the watchdog: `cpu_rst_no` stays high however long the request remains pending.
- R7: `fired_o` sets on the edge where the reset pulse starts and holds until an edge with `clr_fired_i` at 1. If both happen on the same edge, setting wins.
- R8: While `rst_ni` is low, `cpu_rst_no` is 1 and `fired_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset of the block, active low |
| irq_ni | input | 1 | Processor interrupt request, active low |
| user_mode_i | input | 1 | 1 while the processor runs in user mode |
| limit_i | input | LIMIT_W (16) | Trip threshold in cycles; 0 disables the watchdog |
| clr_fired_i | input | 1 | Strobe that clears the fired flag |
| cpu_rst_no | output | 1 | Processor-only reset, active low |
| fired_o | output | 1 | Sticky flag set when the watchdog fires |

## Verification
The bench builds the block with a 16-bit limit and a four-clock pulse. It programs limits of 5, 1 and 0, so the exact trip edge, the smallest possible limit and the disabled case can all be observed within a few dozen cycles. Intervals broken one cycle short of the limit, either by a supervisor cycle or by the request going high, show that each kind of break restarts the count. A set and a clear on the same edge show which one wins.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  parameter int unsigned LIMIT_W_DEF   = 16;
  parameter int unsigned PULSE_LEN_DEF = 4;
endpackage

// File: rtl/wdog_interval.sv
module wdog_interval #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         qualify_i,
  input  logic         hold_i,
  input  logic [W-1:0] limit_i,
  output logic         trip_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         enabled;
  logic         at_end;

  assign enabled = (limit_i != '0);
  // >= guards a limit lowered below the running count
  assign at_end  = ({1'b0, cnt_q} + 1'b1) >= {1'b0, limit_i};
  assign trip_o  = qualify_i && !hold_i && enabled && at_end;

  always_comb begin
    if (hold_i || !qualify_i || !enabled || trip_o) cnt_d = '0;
    else                                            cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  p_count_up_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (qualify_i && !hold_i && enabled && !trip_o) |=> cnt_q == $past(cnt_q) + 1'b1);
  // R2 and R3: any break in qualification zeroes the count
  p_break_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !qualify_i |=> cnt_q == '0);
  p_disabled_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enabled |-> !trip_o);
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int unsigned LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic active_o
);
  localparam int unsigned PW = $clog2(LEN + 1);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (start_i)      cnt_q <= PW'(LEN);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);

  p_pulse_down_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0 && !start_i) |=> cnt_q == PW'($past(cnt_q) - 1'b1));
  p_pulse_start_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> active_o);
endmodule

// File: rtl/irq_starve_wdog.sv
module irq_starve_wdog
  import wdog_pkg::*;
#(
  parameter int unsigned LIMIT_W   = LIMIT_W_DEF,
  parameter int unsigned PULSE_LEN = PULSE_LEN_DEF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               irq_ni,
  input  logic               user_mode_i,
  input  logic [LIMIT_W-1:0] limit_i,
  input  logic               clr_fired_i,
  output logic               cpu_rst_no,
  output logic               fired_o
);
  logic qualify;
  logic trip;
  logic pulse_active;
  logic fired_q;

  assign qualify = user_mode_i && !irq_ni;

  wdog_interval #(.W(LIMIT_W)) u_interval (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .qualify_i(qualify),
    .hold_i   (pulse_active),
    .limit_i  (limit_i),
    .trip_o   (trip)
  );

  wdog_pulse #(.LEN(PULSE_LEN)) u_pulse (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (trip),
    .active_o(pulse_active)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          fired_q <= 1'b0;
    else if (trip)        fired_q <= 1'b1;
    else if (clr_fired_i) fired_q <= 1'b0;
  end

  assign cpu_rst_no = !pulse_active;
  assign fired_o    = fired_q;

  p_fire_cause_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cpu_rst_no) |-> ($past(user_mode_i) && !$past(irq_ni) && $past(limit_i) != '0));
  p_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fired_q && !clr_fired_i) |=> fired_q);
  p_fire_sets_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cpu_rst_no) |-> fired_q);
endmodule

// File: tb/tb_irq_starve_wdog.sv
module tb_irq_starve_wdog;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        irq_ni = 1'b1;
  logic        user_mode_i = 1'b0;
  logic [15:0] limit_i = '0;
  logic        clr_fired_i = 1'b0;
  logic        cpu_rst_no;
  logic        fired_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    bit    rst_n;
    bit    fired;
    string req;
  } exp_t;
  exp_t q[$];

  always #10 clk_i = ~clk_i;

  irq_starve_wdog #(.LIMIT_W(16), .PULSE_LEN(4)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .irq_ni(irq_ni), .user_mode_i(user_mode_i),
    .limit_i(limit_i), .clr_fired_i(clr_fired_i), .cpu_rst_no(cpu_rst_no),
    .fired_o(fired_o)
  );

  task automatic check(input bit act, input bit exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic drive(input bit irq_n, input bit user, input logic [15:0] lim,
                       input bit clr, input bit exp_rst, input bit exp_fired,
                       input string req);
    exp_t e;
    @(negedge clk_i);
    irq_ni = irq_n; user_mode_i = user; limit_i = lim; clr_fired_i = clr;
    e.rst_n = exp_rst; e.fired = exp_fired; e.req = req;
    q.push_back(e);
  endtask

  // remaining pulse cycles after the trip edge, then release
  task automatic drain(input logic [15:0] lim, input bit f, input string req);
    for (int i = 0; i < 3; i++) drive(1'b0, 1'b1, lim, 1'b0, 1'b0, f, req);
    drive(1'b1, 1'b1, lim, 1'b0, 1'b1, f, req);
  endtask

  // monitor: mid high phase, after the edge the expectation refers to
  always @(posedge clk_i) begin
    #5;
    if (q.size() != 0) begin
      exp_t e;
      e = q.pop_front();
      check(cpu_rst_no, e.rst_n, e.req, "cpu_rst_no");
      check(fired_o, e.fired, e.req, "fired_o");
    end
  end

  initial begin
    #35;
    check(cpu_rst_no, 1'b1, "R8", "cpu_rst_no in reset");
    check(fired_o, 1'b0, "R8", "fired_o in reset");
    @(negedge clk_i); rst_ni = 1'b1;

    // limit 5: trip on the 5th qualifying edge, qualifying input ignored in pulse
    for (int i = 0; i < 4; i++) drive(1'b0, 1'b1, 16'd5, 1'b0, 1'b1, 1'b0, "R1");
    drive(1'b0, 1'b1, 16'd5, 1'b0, 1'b0, 1'b1, "R4");
    drain(16'd5, 1'b1, "R5");
    for (int i = 0; i < 4; i++) drive(1'b0, 1'b1, 16'd5, 1'b0, 1'b1, 1'b1, "R5");
    drive(1'b0, 1'b1, 16'd5, 1'b0, 1'b0, 1'b1, "R5");
    drain(16'd5, 1'b1, "R5");
    drive(1'b1, 1'b1, 16'd5, 1'b1, 1'b1, 1'b0, "R7");

    // supervisor cycle breaks the interval
    for (int i = 0; i < 4; i++) drive(1'b0, 1'b1, 16'd5, 1'b0, 1'b1, 1'b0, "R2");
    drive(1'b0, 1'b0, 16'd5, 1'b0, 1'b1, 1'b0, "R2");
    for (int i = 0; i < 4; i++) drive(1'b0, 1'b1, 16'd5, 1'b0, 1'b1, 1'b0, "R2");
    drive(1'b0, 1'b1, 16'd5, 1'b0, 1'b0, 1'b1, "R2");
    drain(16'd5, 1'b1, "R2");
    drive(1'b1, 1'b1, 16'd5, 1'b1, 1'b1, 1'b0, "R7");

    // request released for one cycle breaks the interval
    for (int i = 0; i < 4; i++) drive(1'b0, 1'b1, 16'd5, 1'b0, 1'b1, 1'b0, "R3");
    drive(1'b1, 1'b1, 16'd5, 1'b0, 1'b1, 1'b0, "R3");
    for (int i = 0; i < 4; i++) drive(1'b0, 1'b1, 16'd5, 1'b0, 1'b1, 1'b0, "R3");
    drive(1'b0, 1'b1, 16'd5, 1'b0, 1'b0, 1'b1, "R3");
    drain(16'd5, 1'b1, "R3");
    drive(1'b1, 1'b1, 16'd5, 1'b1, 1'b1, 1'b0, "R7");

    // limit 0 disables
    for (int i = 0; i < 30; i++) drive(1'b0, 1'b1, 16'd0, 1'b0, 1'b1, 1'b0, "R6");

    // limit 1 trips on the first qualifying edge; set wins over clear
    drive(1'b0, 1'b1, 16'd1, 1'b1, 1'b0, 1'b1, "R7");
    drain(16'd1, 1'b1, "R4");
    drive(1'b1, 1'b1, 16'd1, 1'b0, 1'b1, 1'b1, "R7");

    @(negedge clk_i);
    @(negedge clk_i);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule